// File: doc/BRIEF.md
# SDRAM clock-enable power state tracker

This block follows the low-power condition of a DDR SDRAM device as seen by its controller. At every clock edge it compares the clock-enable level now with the level registered at the previous edge, and weighs that pair together with a decoded command and a flag reporting whether any bank holds an open row. From these it reports a two-bit power state. A one-cycle flag marks any edge whose combination the device does not accept.

After a self-refresh exit the block runs two countdowns. The first is a short settling window in which only NOP or deselect may be issued. The second is a longer lockout that holds `read_allowed` low until the device's delay-locked loop has had time to lock. While both clock-enable levels are high, the per-bank command logic owns command legality. The tracker then only mirrors the bank flag into the idle/active state and polices the two countdowns.

Top module: `cke_power_tracker`

## Requirements
- R1: While `rst` is high at a rising edge, and after it, `power_state` is 0 (all banks idle), `illegal` is 0 and `read_allowed` is 1. The registered previous clock-enable level resets high.
- R2: With clock enable low at both the previous and the current edge, and the state power down (2) or self refresh (3), the state is held and `illegal` stays 0 whatever the command.
- R3: A low-to-high clock enable with NOP (1) or deselect (0) while in power down or self refresh leaves the low-power state. The next state is banks active (1) if `any_bank_open` is high, else idle (0). Leaving self refresh starts both countdowns.
- R4: A high-to-low clock enable with NOP or deselect while awake and no bank open moves the state to power down (2).
- R5: A high-to-low clock enable with auto refresh (6) while awake and no bank open moves the state to self refresh (3).
- R6: A high-to-low clock enable with NOP or deselect while a bank is open moves the state to power down (2).
- R7: With clock enable high at both edges and the state idle or active, the state follows `any_bank_open` (1 active, 0 idle).
- R8: For the XSNR_CYCLES edges that follow a self-refresh exit edge, any command other than NOP or deselect raises `illegal`. The first edge after the window accepts any command.
- R9: `read_allowed` is low for READ_LOCK_CYCLES edges after a self-refresh exit edge. A read (3) issued at an edge where `read_allowed` was low raises `illegal`.
- R10: Every other combination raises `illegal` and holds the state. These are: a high-to-low edge with any other command, a low-to-high edge with any other command, a low-power state with clock enable high at the previous edge, and an awake state with clock enable low at the previous edge.
- R11: `illegal` is a registered flag. It is high in the cycle after the offending edge and low otherwise. Command codes: 0 deselect, 1 NOP, 2 activate, 3 read, 4 write, 5 precharge, 6 auto refresh, 7 mode set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock-enable level at this edge |
| cmd | input | 3 | Decoded command code |
| any_bank_open | input | 1 | High when any bank has an open row |
| power_state | output | 2 | 0 idle, 1 active, 2 power down, 3 self refresh |
| illegal | output | 1 | Previous edge carried a rejected combination |
| read_allowed | output | 1 | Low during the post-self-refresh read lockout |

## Verification
Assertions inside the RTL check on every cycle that a low-power state holds silently while clock enable stays low. They also check the three entry transitions, that an exit with NOP leaves no error, that a non-NOP command inside the settling window or a read during the lockout is flagged, and that each countdown steps down by one. The exact length of both windows and the first edge where a command becomes legal can only be shown by the bench scenarios. The same holds for recovery from a refused exit and for the illegal cases that hold the state.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

    typedef enum logic [2:0] {
        CMD_DESEL = 3'd0,
        CMD_NOP   = 3'd1,
        CMD_ACT   = 3'd2,
        CMD_READ  = 3'd3,
        CMD_WRITE = 3'd4,
        CMD_PRE   = 3'd5,
        CMD_AREF  = 3'd6,
        CMD_MODE  = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        PS_IDLE    = 2'd0,
        PS_ACTIVE  = 2'd1,
        PS_PWRDN   = 2'd2,
        PS_SELFREF = 2'd3
    } pstate_e;

    typedef struct packed {
        logic quiet;   // NOP or deselect
        logic rd;      // read
        logic aref;    // auto refresh
    } cmd_class_t;

endpackage

// File: rtl/cke_cmd_class.sv
module cke_cmd_class
    import cke_pwr_pkg::*;
(
    input  logic [2:0]  cmd,
    output cmd_class_t  cls
);
    always_comb begin
        cls       = '0;
        cls.quiet = (cmd == CMD_NOP) || (cmd == CMD_DESEL);
        cls.rd    = (cmd == CMD_READ);
        cls.aref  = (cmd == CMD_AREF);
    end
endmodule

// File: rtl/cke_lock_timer.sv
module cke_lock_timer #(
    parameter int LEN = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int W = $clog2(LEN + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = W'(LEN);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R9: a running countdown steps down by exactly one per edge
    assert_timer_step_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R8: a load always opens a window
    assert_timer_load_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> busy);

endmodule

// File: rtl/cke_power_tracker.sv
module cke_power_tracker
    import cke_pwr_pkg::*;
#(
    parameter int XSNR_CYCLES      = 10,
    parameter int READ_LOCK_CYCLES = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cke,
    input  logic [2:0] cmd,
    input  logic       any_bank_open,
    output logic [1:0] power_state,
    output logic       illegal,
    output logic       read_allowed
);
    typedef struct packed {
        pstate_e st;
        logic    cke;
        logic    ill;
    } trk_t;

    localparam trk_t TRK_RESET = '{st: PS_IDLE, cke: 1'b1, ill: 1'b0};

    trk_t       trk_d, trk_q;
    cmd_class_t cls;
    logic       sr_exit;
    logic       xsnr_busy, rd_busy;
    logic       asleep;
    pstate_e    awake_st;

    cke_cmd_class u_class (.cmd(cmd), .cls(cls));

    cke_lock_timer #(.LEN(XSNR_CYCLES)) u_xsnr (
        .clk(clk), .rst(rst), .load(sr_exit), .busy(xsnr_busy));

    cke_lock_timer #(.LEN(READ_LOCK_CYCLES)) u_rdlock (
        .clk(clk), .rst(rst), .load(sr_exit), .busy(rd_busy));

    assign asleep   = (trk_q.st == PS_PWRDN) || (trk_q.st == PS_SELFREF);
    assign awake_st = any_bank_open ? PS_ACTIVE : PS_IDLE;

    always_comb begin
        trk_d     = trk_q;
        trk_d.cke = cke;
        trk_d.ill = 1'b0;
        sr_exit   = 1'b0;
        unique case ({trk_q.cke, cke})
            2'b00: begin
                if (!asleep) trk_d.ill = 1'b1;
            end
            2'b01: begin
                if (asleep && cls.quiet) begin
                    trk_d.st = awake_st;
                    sr_exit  = (trk_q.st == PS_SELFREF);
                end else begin
                    trk_d.ill = 1'b1;
                end
            end
            2'b10: begin
                if (asleep)
                    trk_d.ill = 1'b1;
                else if (cls.quiet)
                    trk_d.st = PS_PWRDN;
                else if (cls.aref && !any_bank_open)
                    trk_d.st = PS_SELFREF;
                else
                    trk_d.ill = 1'b1;
            end
            default: begin
                if (asleep) begin
                    trk_d.ill = 1'b1;
                end else begin
                    trk_d.st = awake_st;
                    if (xsnr_busy && !cls.quiet) trk_d.ill = 1'b1;
                    if (cls.rd && rd_busy)       trk_d.ill = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) trk_q <= TRK_RESET;
        else     trk_q <= trk_d;
    end

    assign power_state  = trk_q.st;
    assign illegal      = trk_q.ill;
    assign read_allowed = !rd_busy;

    // R2: low-power state held quietly while clock enable stays low
    assert_sleep_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!trk_q.cke && !cke && asleep) |=> ($stable(power_state) && !illegal));

    // R3: a quiet wake-up leaves no error and lands awake
    assert_wake_clean_R3: assert property (@(posedge clk) disable iff (rst)
        (!trk_q.cke && cke && asleep && cls.quiet) |=> (!illegal && !power_state[1]));

    // R4 / R6: quiet high-to-low entry goes to power down
    assert_pd_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (trk_q.cke && !cke && !asleep && cls.quiet) |=> (power_state == 2'd2));

    // R5: auto refresh on falling clock enable enters self refresh
    assert_sr_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (trk_q.cke && !cke && !asleep && cls.aref && !any_bank_open)
        |=> (power_state == 2'd3));

    // R8: busy command inside the exit window is rejected
    assert_xsnr_guard_R8: assert property (@(posedge clk) disable iff (rst)
        (trk_q.cke && cke && xsnr_busy && !cls.quiet) |=> illegal);

    // R9: read during lockout is rejected
    assert_read_lock_R9: assert property (@(posedge clk) disable iff (rst)
        (trk_q.cke && cke && cls.rd && !read_allowed) |=> illegal);

endmodule

// File: tb/cke_power_tracker_tb.sv
`timescale 1ns/1ps
module cke_power_tracker_tb_top;
    localparam int XS = 4;
    localparam int RL = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cke = 1'b1;
    logic [2:0] cmd = 3'd1;
    logic       any_bank_open = 1'b0;
    logic [1:0] power_state;
    logic       illegal;
    logic       read_allowed;

    int checks = 0;
    int failures = 0;
    bit tracking = 1'b0;
    int since = 0;

    typedef struct {
        logic [1:0] st;
        logic       ill;
        logic       ra;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    cke_power_tracker #(.XSNR_CYCLES(XS), .READ_LOCK_CYCLES(RL)) dut_i (
        .clk(clk), .rst(rst), .cke(cke), .cmd(cmd),
        .any_bank_open(any_bank_open), .power_state(power_state),
        .illegal(illegal), .read_allowed(read_allowed));

    task automatic drv(input logic c, input logic [2:0] k, input logic open,
                       input logic [1:0] est, input logic eill,
                       input bit arm, input string tag);
        exp_t e;
        @(negedge clk);
        cke = c; cmd = k; any_bank_open = open;
        if (arm) begin tracking = 1'b1; since = 0; end
        else if (tracking) since++;
        e.st = est; e.ill = eill;
        e.ra = tracking ? (since >= RL) : 1'b1;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() != 0) begin
                e = sb_q.pop_front();
                checks++;
                if (power_state !== e.st || illegal !== e.ill || read_allowed !== e.ra) begin
                    failures++;
                    $display("FAIL %s: got st=%0d ill=%0b ra=%0b exp st=%0d ill=%0b ra=%0b",
                             e.tag, power_state, illegal, read_allowed, e.st, e.ill, e.ra);
                end
            end
        end
    end

    task automatic scenario();
        repeat (3) @(negedge clk);
        checks++;
        if (power_state !== 2'd0 || illegal !== 1'b0 || read_allowed !== 1'b1) begin
            failures++;
            $display("FAIL R1: got st=%0d ill=%0b ra=%0b exp st=0 ill=0 ra=1",
                     power_state, illegal, read_allowed);
        end
        rst = 1'b0;
        drv(1, 3'd1, 0, 2'd0, 0, 0, "R1 first edge after reset");
        drv(1, 3'd1, 1, 2'd1, 0, 0, "R7 follows open bank");
        drv(0, 3'd1, 1, 2'd2, 0, 0, "R6 active power down");
        drv(0, 3'd2, 1, 2'd2, 0, 0, "R2 command ignored in power down");
        drv(1, 3'd1, 1, 2'd1, 0, 0, "R3 exit to active");
        drv(1, 3'd1, 0, 2'd0, 0, 0, "R7 back to idle");
        drv(0, 3'd0, 0, 2'd2, 0, 0, "R4 precharge power down");
        drv(1, 3'd3, 0, 2'd2, 1, 0, "R10 exit with read refused");
        drv(1, 3'd1, 0, 2'd2, 1, 0, "R10 asleep with high enable");
        drv(0, 3'd1, 0, 2'd2, 1, 0, "R10 asleep falling edge");
        drv(1, 3'd0, 0, 2'd0, 0, 0, "R3 recovered exit to idle");
        drv(0, 3'd4, 0, 2'd0, 1, 0, "R10 falling edge with write");
        drv(1, 3'd1, 0, 2'd0, 1, 0, "R10 awake rising edge");
        drv(0, 3'd6, 1, 2'd0, 1, 0, "R10 refresh with open bank");
        drv(1, 3'd1, 0, 2'd0, 1, 0, "R11 rising edge while awake");
        drv(1, 3'd1, 0, 2'd0, 0, 0, "R11 flag clears");
        drv(0, 3'd6, 0, 2'd3, 0, 0, "R5 self refresh entry");
        drv(0, 3'd3, 0, 2'd3, 0, 0, "R2 read ignored in self refresh");
        drv(0, 3'd7, 0, 2'd3, 0, 0, "R2 mode set ignored in self refresh");
        drv(1, 3'd1, 0, 2'd0, 0, 1, "R3 self refresh exit");
        drv(1, 3'd2, 0, 2'd0, 1, 0, "R8 activate in window");
        drv(1, 3'd1, 0, 2'd0, 0, 0, "R8 nop in window");
        drv(1, 3'd0, 0, 2'd0, 0, 0, "R8 deselect in window");
        drv(1, 3'd5, 0, 2'd0, 1, 0, "R8 last window edge");
        drv(1, 3'd2, 1, 2'd1, 0, 0, "R8 first edge after window");
        drv(1, 3'd3, 1, 2'd1, 1, 0, "R9 early read");
        for (int i = 0; i < RL - 7; i++)
            drv(1, 3'd1, 1, 2'd1, 0, 0, "R9 lockout wait");
        drv(1, 3'd3, 1, 2'd1, 1, 0, "R9 read on last lockout edge");
        drv(1, 3'd3, 1, 2'd1, 0, 0, "R9 read after lockout");
        drv(1, 3'd1, 1, 2'd1, 0, 0, "R7 settle");
        repeat (3) @(negedge clk);
    endtask

    initial begin : main
        bit timed_out = 1'b0;
        fork
            scenario();
            begin
                repeat (5000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got hang exp completion");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule